// File: doc/BRIEF.md
# NAND Read Command Sequencer

This block launches a single page read on a raw NAND flash device connected through an 8-bit parallel bus. A request supplies a block number, a page inside that block, a column offset and an opcode. The sequencer latches the request and waits for the device ready line. It then clocks the opcode onto the bus as a command byte, followed by the column and row address bytes. After the last byte it releases chip enable, waits for the device to report ready again, and pulses `done`.

Parameters choose between the small-page address format and the large-page format. In large-page mode the address phase ends with a read-start confirm command. A request whose opcode is the out-of-band read code is turned into a plain read: the column is moved past the end of the page data. When the device bus is 16 bits wide, the large-page column is given as a word address. Moving the data itself is left to other logic.

The controller runs through seven states. `ST_IDLE` moves to `ST_WAIT_PRE` when a request is accepted. `ST_WAIT_PRE` moves to `ST_SETUP` once ready is high. For each byte, `ST_SETUP` presents the byte, `ST_STROBE` holds the write strobe low for the configured width, and `ST_HOLD` keeps the data stable after the strobe rises. From `ST_HOLD` the controller goes back to `ST_SETUP` for the next byte, or to `ST_WAIT_POST` after the last one. `ST_WAIT_POST` moves to `ST_DONE` when ready returns, and `ST_DONE` goes back to `ST_IDLE`.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the outputs are idle: `nand_ce_n`=1, `nand_we_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_io`=0, `busy`=0, `done`=0.
- R2: After accepting a request, no byte is strobed and chip enable stays high while `nand_rdy` is low. The first byte starts only in the cycle after ready was seen high.
- R3: The row address equals page + block × PAGES_PER_BLOCK, sent as row[7:0] first, then row[15:8], then (when the extra cycle is enabled) {4'h0, row[19:16]}.
- R4: In large-page mode the bytes, in order, are: the opcode with CLE, column[7:0] with ALE, column[15:8] with ALE, the row bytes of R3 with ALE, and then the read-start opcode (default 0x30) with CLE.
- R5: In small-page mode the bytes, in order, are: the opcode with CLE, column[7:0] with ALE, and then the row bytes of R3 with ALE. No confirm command is sent.
- R6: In large-page mode, a request whose opcode equals the out-of-band read code (default 0x50) sends the read opcode (default 0x00) instead, and its column becomes column + PAGE_BYTES.
- R7: With a 16-bit device bus in large-page mode, the column sent is the value from R6 shifted right by one.
- R8: CLE and ALE are never high together. The write strobe is low only while chip enable is low, for exactly WE_LOW cycles (WE_LOW ≥ 2) per byte. Data, CLE and ALE stay stable while the strobe is low and for the cycle in which it rises.
- R9: After the last byte, chip enable goes high and the block waits for `nand_rdy`. `done` is a single-cycle pulse that follows a cycle with ready high.
- R10: A request made while `busy` is high has no effect on the byte sequence in progress. It raises `req_err` for exactly one cycle, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only in ST_IDLE |
| req_block | input | BLOCK_W | Erase block number |
| req_page | input | PAGE_W | Page within the block |
| req_col | input | COL_W | Byte column offset |
| req_opcode | input | 8 | Read opcode requested |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle pulse for a request made while busy |
| nand_rdy | input | 1 | Device ready (high) / busy (low) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | 8 | Bus byte |

## Verification
The assertions check bus-level rules on every cycle. These are: CLE and ALE never high together, the strobe only under chip enable, a strobe of at least two cycles, data stable across the strobe and its rising edge, the first byte only after ready, `done` as a lone pulse after ready, and `req_err` exactly when a request meets a busy sequencer. Other behaviours depend on the whole request, and only the bench scenarios can show them. These are the exact byte order for each format, the row arithmetic, the out-of-band column shift, the word-address shift, the exact strobe width, and whether an ignored request left the sequence in progress untouched.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam int ROW_W = 20;
    localparam int COLF_W = 16;
    localparam int IDX_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PRE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_WAIT_POST,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/nand_addr_map.sv
module nand_addr_map
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE      = 1,
    parameter int BUS16           = 0,
    parameter int PAGE_BYTES      = 2048,
    parameter int PAGES_PER_BLOCK = 64,
    parameter int BLOCK_W         = 12,
    parameter int PAGE_W          = 6,
    parameter int COL_W           = 12,
    parameter logic [7:0] OP_READ = 8'h00,
    parameter logic [7:0] OP_OOB  = 8'h50
) (
    input  logic [BLOCK_W-1:0] blk,
    input  logic [PAGE_W-1:0]  pg,
    input  logic [COL_W-1:0]   col,
    input  logic [7:0]         opcode,
    output logic [7:0]         eff_op,
    output logic [ROW_W-1:0]   row,
    output logic [COLF_W-1:0]  col_eff
);
    logic [COLF_W:0] col_ext;

    always_comb begin
        row     = ROW_W'(blk) * ROW_W'(PAGES_PER_BLOCK) + ROW_W'(pg);
        col_ext = (COLF_W+1)'(col);
        eff_op  = opcode;
        if (LARGE_PAGE != 0 && opcode == OP_OOB) begin
            col_ext = col_ext + (COLF_W+1)'(PAGE_BYTES);
            eff_op  = OP_READ;
        end
        col_eff = (LARGE_PAGE != 0 && BUS16 != 0) ? col_ext[COLF_W:1] : col_ext[COLF_W-1:0];
    end
endmodule

// File: rtl/nand_byte_sel.sv
module nand_byte_sel
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE       = 1,
    parameter int EXTRA_ROW_CYCLE  = 1,
    parameter logic [7:0] OP_START = 8'h30
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        op,
    input  logic [ROW_W-1:0]  row,
    input  logic [COLF_W-1:0] col,
    output logic [7:0]        bus_byte,
    output logic              is_cmd,
    output logic              last
);
    localparam int NCYC = (LARGE_PAGE != 0) ? ((EXTRA_ROW_CYCLE != 0) ? 7 : 6)
                                            : ((EXTRA_ROW_CYCLE != 0) ? 5 : 4);
    localparam int ROWB = (LARGE_PAGE != 0) ? 3 : 2;

    always_comb begin
        last     = (idx == IDX_W'(NCYC - 1));
        is_cmd   = 1'b0;
        bus_byte = 8'h00;
        if (idx == '0) begin
            is_cmd   = 1'b1;
            bus_byte = op;
        end else if (LARGE_PAGE != 0 && last) begin
            is_cmd   = 1'b1;
            bus_byte = OP_START;
        end else if (idx == IDX_W'(1)) begin
            bus_byte = col[7:0];
        end else if (LARGE_PAGE != 0 && idx == IDX_W'(2)) begin
            bus_byte = col[15:8];
        end else if (idx == IDX_W'(ROWB)) begin
            bus_byte = row[7:0];
        end else if (idx == IDX_W'(ROWB + 1)) begin
            bus_byte = row[15:8];
        end else begin
            bus_byte = {4'h0, row[19:16]};
        end
    end
endmodule

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
    parameter int WE_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(WE_LOW + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(WE_LOW - 1);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE       = 1,
    parameter int EXTRA_ROW_CYCLE  = 1,
    parameter int BUS16            = 0,
    parameter int PAGE_BYTES       = 2048,
    parameter int PAGES_PER_BLOCK  = 64,
    parameter int BLOCK_W          = 12,
    parameter int PAGE_W           = 6,
    parameter int COL_W            = 12,
    parameter int WE_LOW           = 2,
    parameter logic [7:0] OP_READ  = 8'h00,
    parameter logic [7:0] OP_OOB   = 8'h50,
    parameter logic [7:0] OP_START = 8'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [BLOCK_W-1:0] req_block,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [COL_W-1:0]   req_col,
    input  logic [7:0]         req_opcode,
    output logic               busy,
    output logic               done,
    output logic               req_err,
    input  logic               nand_rdy,
    output logic               nand_cle,
    output logic               nand_ale,
    output logic               nand_ce_n,
    output logic               nand_we_n,
    output logic [7:0]         nand_io
);
    seq_state_t state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [7:0]        op_q,  op_w;
    logic [ROW_W-1:0]  row_q, row_w;
    logic [COLF_W-1:0] col_q, col_w;
    logic              err_q;
    logic [7:0]        byte_w;
    logic              is_cmd, last, expired, accept, in_byte;

    nand_addr_map #(
        .LARGE_PAGE(LARGE_PAGE), .BUS16(BUS16), .PAGE_BYTES(PAGE_BYTES),
        .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W),
        .COL_W(COL_W), .OP_READ(OP_READ), .OP_OOB(OP_OOB)
    ) u_map (
        .blk(req_block), .pg(req_page), .col(req_col), .opcode(req_opcode),
        .eff_op(op_w), .row(row_w), .col_eff(col_w)
    );

    nand_byte_sel #(
        .LARGE_PAGE(LARGE_PAGE), .EXTRA_ROW_CYCLE(EXTRA_ROW_CYCLE), .OP_START(OP_START)
    ) u_sel (
        .idx(idx_q), .op(op_q), .row(row_q), .col(col_q),
        .bus_byte(byte_w), .is_cmd(is_cmd), .last(last)
    );

    nand_we_timer #(.WE_LOW(WE_LOW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(state_q == ST_SETUP), .expired(expired)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_WAIT_PRE;
            ST_WAIT_PRE:  if (nand_rdy)  state_d = ST_SETUP;
            ST_SETUP:                    state_d = ST_STROBE;
            ST_STROBE:    if (expired)   state_d = ST_HOLD;
            ST_HOLD:                     state_d = last ? ST_WAIT_POST : ST_SETUP;
            ST_WAIT_POST: if (nand_rdy)  state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            op_q    <= '0;
            row_q   <= '0;
            col_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= req_valid && (state_q != ST_IDLE);
            if (accept) begin
                idx_q <= '0;
                op_q  <= op_w;
                row_q <= row_w;
                col_q <= col_w;
            end else if (state_q == ST_HOLD && !last) begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        in_byte   = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        req_err   = err_q;
        nand_ce_n = !in_byte;
        nand_we_n = (state_q != ST_STROBE);
        nand_cle  = in_byte && is_cmd;
        nand_ale  = in_byte && !is_cmd;
        nand_io   = in_byte ? byte_w : 8'h00;
    end
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       req_err,
    input logic       nand_rdy,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_ce_n,
    input logic       nand_we_n,
    input logic [7:0] nand_io
);
    assert_wait_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_ce_n) |-> $past(nand_rdy));

    assert_cle_ale_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_strobe_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);

    assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_we_n) |=> !nand_we_n);

    assert_io_low_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!nand_we_n && $past(!nand_we_n)) |-> $stable(nand_io));

    assert_io_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_io) && $stable(nand_cle) && $stable(nand_ale)));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_rdy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(nand_rdy) && nand_ce_n));

    assert_busy_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && busy) |=> req_err);

    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid && busy));
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (.*);

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
    localparam int NI   = 3;       // 0: large 5-cycle, 1: small 4+1, 2: large 16-bit 4-cycle
    localparam int BUSY = 12;
    localparam int WEL  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [11:0] req_block = '0;
    logic [5:0]  req_page  = '0;
    logic [11:0] req_col   = '0;
    logic [7:0]  req_op    = '0;
    logic        force_low = 1'b0;

    logic [NI-1:0] busy, done, req_err, rdy, cle, ale, ce_n, we_n;
    logic [7:0]    io [NI];

    logic [9:0] cap [NI][8];
    int cap_n [NI], busy_cnt [NI], done_lat [NI], err_cnt [NI], low_w [NI], bad_w [NI];
    bit done_seen [NI], lat_on [NI], prev_we [NI], prev_ce [NI];

    int n_chk = 0, n_fail = 0, cyc = 0;

    for (genvar i = 0; i < NI; i++) begin : gen_dut
        nand_cmd_seq #(
            .LARGE_PAGE(i != 1), .EXTRA_ROW_CYCLE(i != 2), .BUS16(i == 2),
            .PAGE_BYTES((i == 1) ? 512 : 2048)
        ) u_nand_cmd_seq (
            .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_block(req_block),
            .req_page(req_page), .req_col(req_col), .req_opcode(req_op),
            .busy(busy[i]), .done(done[i]), .req_err(req_err[i]), .nand_rdy(rdy[i]),
            .nand_cle(cle[i]), .nand_ale(ale[i]), .nand_ce_n(ce_n[i]),
            .nand_we_n(we_n[i]), .nand_io(io[i])
        );
        assign rdy[i] = !force_low && (busy_cnt[i] == 0);
    end

    // device model and bus monitor, sampled on the falling edge
    always @(negedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (!rst_n) begin
                cap_n[i] = 0; busy_cnt[i] = 0; done_lat[i] = 0; err_cnt[i] = 0;
                low_w[i] = 0; bad_w[i] = 0; done_seen[i] = 0; lat_on[i] = 0;
                prev_we[i] = 1; prev_ce[i] = 1;
            end else begin
                if (req_valid && !busy[i]) begin
                    cap_n[i] = 0; done_seen[i] = 0; err_cnt[i] = 0;
                    done_lat[i] = 0; lat_on[i] = 0; bad_w[i] = 0;
                end
                if (!we_n[i]) low_w[i]++;
                if (!prev_we[i] && we_n[i]) begin
                    if (cap_n[i] < 8) cap[i][cap_n[i]] = {cle[i], ale[i], io[i]};
                    cap_n[i]++;
                    if (low_w[i] != WEL) bad_w[i]++;
                    low_w[i] = 0;
                end
                if (!prev_ce[i] && ce_n[i]) begin
                    busy_cnt[i] = BUSY;
                    lat_on[i] = 1;
                end else if (busy_cnt[i] > 0) begin
                    busy_cnt[i]--;
                end
                if (lat_on[i]) done_lat[i]++;
                if (done[i]) begin
                    done_seen[i] = 1;
                    lat_on[i] = 0;
                end
                if (req_err[i]) err_cnt[i]++;
                prev_we[i] = we_n[i];
                prev_ce[i] = ce_n[i];
            end
        end
    end

    // {block, page, col, opcode}
    localparam logic [37:0] VEC [4] = '{
        {12'h000, 6'd0,  12'h000, 8'h00},
        {12'h005, 6'd3,  12'h123, 8'h00},
        {12'hABC, 6'd63, 12'h7FF, 8'h50},
        {12'hFFF, 6'd63, 12'h010, 8'h50}
    };

    function automatic int exp_count(int i);
        if (i == 0) return 7;
        if (i == 1) return 5;
        return 6;
    endfunction

    function automatic logic [9:0] exp_entry(int i, int k, logic [11:0] b, logic [5:0] p,
                                             logic [11:0] c, logic [7:0] op);
        logic [9:0]  s [8];
        logic [31:0] row;
        logic [31:0] col;
        logic [7:0]  o;
        int n;
        row = 32'(b) * 64 + 32'(p);
        col = 32'(c);
        o = op;
        if (i != 1 && op == 8'h50) begin
            col = col + ((i == 1) ? 512 : 2048);
            o = 8'h00;
        end
        if (i == 2) col = col >> 1;
        s[0] = {2'b10, o};
        s[1] = {2'b01, col[7:0]};
        n = 2;
        if (i != 1) begin s[2] = {2'b01, col[15:8]}; n = 3; end
        s[n] = {2'b01, row[7:0]};
        s[n+1] = {2'b01, row[15:8]};
        n = n + 2;
        if (i != 2) begin s[n] = {2'b01, 4'h0, row[19:16]}; n++; end
        if (i != 1) s[n] = {2'b10, 8'h30};
        return s[k];
    endfunction

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic send(input logic [37:0] v);
        @(posedge clk); #1;
        {req_block, req_page, req_col, req_op} = v;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            if (done_seen[0] && done_seen[1] && done_seen[2]) break;
        end
    endtask

    task automatic check_seq(input logic [37:0] v);
        string tag;
        logic [9:0] e;
        for (int i = 0; i < NI; i++) begin
            tag = (i == 1) ? "R5" : ((i == 2) ? "R7" : "R4");
            if (i != 1 && v[7:0] == 8'h50) tag = "R6";
            check(done_seen[i], $sformatf("R9 done inst %0d", i), 32'(done_seen[i]), 1);
            check(cap_n[i] == exp_count(i), $sformatf("%s count inst %0d", tag, i),
                  32'(cap_n[i]), 32'(exp_count(i)));
            for (int k = 0; k < exp_count(i) && k < 8; k++) begin
                e = exp_entry(i, k, v[37:26], v[25:20], v[19:8], v[7:0]);
                check(cap[i][k] == e,
                      $sformatf("%s byte %0d inst %0d", (k >= ((i == 1) ? 2 : 3) && e[9:8] == 2'b01) ? "R3" : tag, k, i),
                      32'(cap[i][k]), 32'(e));
            end
            check(bad_w[i] == 0, $sformatf("R8 strobe width inst %0d", i), 32'(bad_w[i]), 0);
            check(done_lat[i] >= BUSY, $sformatf("R9 ready wait inst %0d", i), 32'(done_lat[i]), BUSY);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            check(ce_n[i] && we_n[i] && !cle[i] && !ale[i] && io[i] == 8'h00 && !busy[i] && !done[i],
                  $sformatf("R1 reset idle inst %0d", i),
                  {ce_n[i], we_n[i], cle[i], ale[i], busy[i], done[i], io[i]}, 32'h3000);
        end

        // table walk
        for (int v = 0; v < 4; v++) begin
            send(VEC[v]);
            wait_done();
            check_seq(VEC[v]);
            repeat (3) @(posedge clk);
        end

        // R2: hold ready low, nothing may be strobed
        @(posedge clk); #1 force_low = 1'b1;
        send(VEC[1]);
        repeat (40) @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            check(cap_n[i] == 0 && ce_n[i], $sformatf("R2 no byte before ready inst %0d", i), 32'(cap_n[i]), 0);
        end
        @(posedge clk); #1 force_low = 1'b0;
        wait_done();
        check_seq(VEC[1]);
        repeat (3) @(posedge clk);

        // R10: second request while busy is ignored and flagged
        send(VEC[1]);
        repeat (4) @(posedge clk);
        send(VEC[3]);
        wait_done();
        for (int i = 0; i < NI; i++) begin
            check(err_cnt[i] == 1, $sformatf("R10 error pulse inst %0d", i), 32'(err_cnt[i]), 1);
        end
        check_seq(VEC[1]);
        repeat (5) @(negedge clk);
        for (int i = 0; i < NI; i++) begin
            check(!busy[i] && ce_n[i], $sformatf("R10 back to idle inst %0d", i), 32'(busy[i]), 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule